// File: doc/BRIEF.md
# Propagate Partial SAD Engine

This block computes sum-of-absolute-difference costs for one 16x16 current macroblock against a stream of reference rows. The 256 current pixels sit in a 16-row array. Each cycle that `ref_valid` is high, one row of 16 reference pixels is broadcast to every row of that array. Each array row forms two half-row costs, one for the left eight columns and one for the right eight. These costs add onto the partial sums handed down from the row above, and the result moves one row further down on every valid cycle. A candidate is any run of 16 consecutive valid reference rows. From the 16th valid row on, every valid row completes one candidate, and the block presents 17 costs for it at once: eight 8x4, four 8x8, two 16x8, two 8x16 and one 16x16.

A new macroblock is written row by row into a shadow store through the load port. It becomes current when `mb_switch` is raised together with a valid reference row. That row is the top row of the first candidate to use the new data. The switch travels down the array alongside the partial sums, so candidates already in flight finish against the macroblock they started with. The shadow store must not be written in the switch cycle, nor during the 15 valid rows that follow it.

Top module: `ppsad_engine`

## Requirements
- R1: While reset is low, and after it is released, `sad_valid` is low and every SAD output reads zero. `sad_valid` stays low for the first 15 valid reference rows after reset.
- R2: Row i of a candidate is the i-th of its 16 consecutive valid rows. Column c of `ref_pix` and `ld_pix` is bits [8c+7:8c], and `ld_row` selects the row that is written. Field k = 2s+h of `sad8x4` (bits [13k+12:13k]) is the SAD over rows 4s..4s+3 and columns 8h..8h+7.
- R3: Field 2v+h of `sad8x8` (14 bits each) is the SAD over rows 8v..8v+7 and columns 8h..8h+7.
- R4: Field v of `sad16x8` (15 bits each) covers rows 8v..8v+7 across all 16 columns. Field h of `sad8x16` (15 bits each) covers all 16 rows in columns 8h..8h+7.
- R5: `sad16x16` is the SAD over the whole macroblock. Its largest value, 65280, must appear without overflow.
- R6: A candidate's costs appear with `sad_valid` high in the cycle after the valid cycle that carries its 16th row. At all other times the outputs hold their last value.
- R7: A cycle with `ref_valid` low does not advance the pipeline. `sad_valid` is low in the next cycle and the SAD outputs do not change.
- R8: When `mb_switch` is high with a valid row, every candidate whose top row is that row or a later one uses the shadow contents of that cycle. Candidates that started earlier use the previous macroblock for all 16 of their rows.
- R9: Writes to the shadow store have no effect on any SAD until the next `mb_switch`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Write one shadow macroblock row |
| ld_row | input | 4 | Shadow row index |
| ld_pix | input | 128 | Sixteen 8-bit current pixels, column 0 in the low byte |
| ref_valid | input | 1 | Reference row present |
| ref_pix | input | 128 | Sixteen 8-bit reference pixels, column 0 in the low byte |
| mb_switch | input | 1 | Shadow macroblock becomes current from this row's candidate on |
| sad_valid | output | 1 | SAD outputs hold a new candidate |
| sad8x4 | output | 104 | Eight 13-bit 8x4 costs |
| sad8x8 | output | 56 | Four 14-bit 8x8 costs |
| sad16x8 | output | 30 | Two 15-bit 16x8 costs |
| sad8x16 | output | 30 | Two 15-bit 8x16 costs |
| sad16x16 | output | 16 | 16-bit 16x16 cost |

## Verification
Two cases drive all-zero pixels against all-255 pixels. In one the current block holds the 255s, in the other the reference holds them. Both drive every field to its ceiling, which exposes truncated widths and half-swapped absolute differences. Random data, a checkerboard and a row-column gradient scramble which rows and columns contribute, so a wrong strip, half or row-delay alignment gives the wrong sum. Each new macroblock is switched in while the window is still full of older rows, so the mixed candidates separate a correct per-row handover from an immediate swap. Idle gaps, shadow writes without a switch and a mid-run reset check that nothing moves when it must not.

// File: rtl/ppsad_engine.sv
`timescale 1ns/1ps
module ppsad_engine #(
  parameter int PW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_en,
  input  logic [3:0]         ld_row,
  input  logic [16*PW-1:0]   ld_pix,
  input  logic               ref_valid,
  input  logic [16*PW-1:0]   ref_pix,
  input  logic               mb_switch,
  output logic               sad_valid,
  output logic [8*(PW+5)-1:0] sad8x4,
  output logic [4*(PW+6)-1:0] sad8x8,
  output logic [2*(PW+7)-1:0] sad16x8,
  output logic [2*(PW+7)-1:0] sad8x16,
  output logic [PW+7:0]       sad16x16
);
  localparam int N  = 16;
  localparam int H  = N / 2;
  localparam int SW = PW + 3;
  localparam int W4 = PW + 5;
  localparam int W8 = PW + 6;
  localparam int WM = PW + 7;
  localparam int WT = PW + 8;

  function automatic logic [PW-1:0] adiff(input logic [PW-1:0] a, input logic [PW-1:0] b);
    return (a > b) ? a - b : b - a;
  endfunction

  logic [N*PW-1:0] sh [N];
  logic [3:0]      fill;
  logic            full;

  always_ff @(posedge clk) if (ld_en) sh[ld_row] <= ld_pix;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) fill <= '0;
    else if (ref_valid && !full) fill <= fill + 4'd1;
  assign full = (fill == 4'd15);

  for (genvar r = 0; r < N; r++) begin : g_row
    logic [N*PW-1:0] a, cur;
    logic [SW-1:0]   hsum [2];
    logic [W4-1:0]   n [8];
    logic            tk;

    if (r == 0) begin : g_t0
      assign tk = mb_switch;
    end else begin : g_tn
      logic tq;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) tq <= 1'b0;
        else if (ref_valid) tq <= g_row[r-1].tk;
      assign tk = tq;
    end

    always_ff @(posedge clk) if (ref_valid && tk) a <= sh[r];
    assign cur = tk ? sh[r] : a;

    always_comb begin
      for (int s = 0; s < 2; s++) begin
        hsum[s] = '0;
        for (int c = 0; c < H; c++)
          hsum[s] = hsum[s] + SW'(adiff(ref_pix[(s*H+c)*PW +: PW], cur[(s*H+c)*PW +: PW]));
      end
    end

    for (genvar k = 0; k < 8; k++) begin : g_k
      if (k/2 == r/4) begin : g_acc
        if (r % 4 == 0) begin : g_first
          assign n[k] = W4'(hsum[k%2]);
        end else begin : g_more
          assign n[k] = g_row[r-1].g_reg.q[k] + W4'(hsum[k%2]);
        end
      end else if (k/2 < r/4) begin : g_pass
        assign n[k] = g_row[r-1].g_reg.q[k];
      end else begin : g_idle
        assign n[k] = '0;
      end
    end

    if (r < N-1) begin : g_reg
      logic [W4-1:0] q [8];
      always_ff @(posedge clk) if (ref_valid) q <= n;
    end
  end

  logic [W8-1:0] e8 [4];
  logic [WM-1:0] e16x8 [2];
  logic [WM-1:0] e8x16 [2];
  logic [WT-1:0] et;

  always_comb begin
    for (int v = 0; v < 2; v++)
      for (int h = 0; h < 2; h++)
        e8[2*v+h] = W8'(g_row[N-1].n[4*v+h]) + W8'(g_row[N-1].n[4*v+2+h]);
    for (int i = 0; i < 2; i++) begin
      e16x8[i] = WM'(e8[2*i]) + WM'(e8[2*i+1]);
      e8x16[i] = WM'(e8[i]) + WM'(e8[2+i]);
    end
    et = WT'(e16x8[0]) + WT'(e16x8[1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sad_valid <= 1'b0;
      sad8x4    <= '0;
      sad8x8    <= '0;
      sad16x8   <= '0;
      sad8x16   <= '0;
      sad16x16  <= '0;
    end else begin
      sad_valid <= ref_valid && full;
      if (ref_valid && full) begin
        for (int k = 0; k < 8; k++) sad8x4[k*W4 +: W4] <= g_row[N-1].n[k];
        for (int k = 0; k < 4; k++) sad8x8[k*W8 +: W8] <= e8[k];
        for (int k = 0; k < 2; k++) begin
          sad16x8[k*WM +: WM] <= e16x8[k];
          sad8x16[k*WM +: WM] <= e8x16[k];
        end
        sad16x16 <= et;
      end
    end
  end
endmodule

module ppsad_engine_chk #(
  parameter int PW = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ref_valid,
  input logic                sad_valid,
  input logic [8*(PW+5)-1:0] sad8x4,
  input logic [4*(PW+6)-1:0] sad8x8,
  input logic [2*(PW+7)-1:0] sad16x8,
  input logic [2*(PW+7)-1:0] sad8x16,
  input logic [PW+7:0]       sad16x16
);
  localparam int W4 = PW + 5;
  localparam int W8 = PW + 6;
  localparam int WM = PW + 7;
  localparam int WT = PW + 8;

  logic [4:0] seen;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen <= '0;
    else if (ref_valid && seen != 5'd16) seen <= seen + 5'd1;

  // R1
  warmup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sad_valid |-> seen == 5'd16);

  // R7
  idle_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_valid |=> !sad_valid);

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_valid |=> $stable(sad16x16) && $stable(sad8x4));

  // R5
  total_cols_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sad_valid |-> sad16x16 == WT'(sad8x16[0 +: WM]) + WT'(sad8x16[WM +: WM]));

  // R3
  total_quads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sad_valid |-> sad16x16 == WT'(sad8x8[0 +: W8]) + WT'(sad8x8[W8 +: W8])
                            + WT'(sad8x8[2*W8 +: W8]) + WT'(sad8x8[3*W8 +: W8]));

  // R2
  top_strips_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sad_valid |-> sad16x8[0 +: WM] == WM'(sad8x4[0 +: W4]) + WM'(sad8x4[W4 +: W4])
                                    + WM'(sad8x4[2*W4 +: W4]) + WM'(sad8x4[3*W4 +: W4]));

  // R4
  left_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sad_valid |-> sad8x16[0 +: WM] == WM'(sad8x8[0 +: W8]) + WM'(sad8x8[2*W8 +: W8]));
endmodule

bind ppsad_engine ppsad_engine_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .sad_valid(sad_valid),
  .sad8x4(sad8x4), .sad8x8(sad8x8), .sad16x8(sad16x8), .sad8x16(sad8x16),
  .sad16x16(sad16x16)
);

// File: tb/ppsad_engine_tb.sv
`timescale 1ns/1ps
module ppsad_engine_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         rst_n, ld_en, ref_valid, mb_switch;
  logic [3:0]   ld_row;
  logic [127:0] ld_pix, ref_pix;
  logic         sad_valid;
  logic [103:0] sad8x4;
  logic [55:0]  sad8x8;
  logic [29:0]  sad16x8, sad8x16;
  logic [15:0]  sad16x16;

  ppsad_engine u_dut (.*);

  int tests = 0, fails = 0;
  logic [7:0] hist [0:1023][0:15];
  int         selhist [0:1023];
  logic [7:0] snaps [0:15][0:15][0:15];
  logic [7:0] shm [0:15][0:15];
  int h = 0, nsnap = 0, cur_id = 0;
  bit r9_phase = 0;

  // cur[7:4] / ref[3:0] pattern modes: 0 zero, 1 all 255, 2 random, 3 checker, 4 gradient, 5 inverse checker
  localparam logic [7:0] VEC [5] = '{8'h10, 8'h01, 8'h22, 8'h35, 8'h42};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got %0d exp %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pix(input int mode, input int r, input int c);
    case (mode)
      0: return 8'd0;
      1: return 8'd255;
      2: return 8'($urandom);
      3: return ((r + c) % 2) ? 8'd255 : 8'd0;
      4: return 8'((r * 16 + c) & 255);
      default: return ((r + c) % 2) ? 8'd0 : 8'd255;
    endcase
  endfunction

  function automatic logic [127:0] mkrow(input int mode, input int r);
    logic [127:0] v;
    for (int c = 0; c < 16; c++) v[c*8 +: 8] = pix(mode, r, c);
    return v;
  endfunction

  function automatic int rsad(input int t, input int r0, input int nr, input int c0, input int nc);
    int s = 0;
    for (int r = 0; r < nr; r++)
      for (int c = 0; c < nc; c++) begin
        int d = int'(hist[t+r0+r][c0+c]) - int'(snaps[selhist[t]][r0+r][c0+c]);
        s += (d < 0) ? -d : d;
      end
    return s;
  endfunction

  task automatic check_cand(input int t);
    string tg = (selhist[t] != selhist[t+15]) ? "R8" : (r9_phase ? "R9" : "R6");
    for (int s = 0; s < 4; s++)
      for (int hh = 0; hh < 2; hh++) begin
        int e = rsad(t, 4*s, 4, 8*hh, 8);
        int a = int'(sad8x4[(2*s+hh)*13 +: 13]);
        chk(a == e, {tg, "/R2 8x4"}, a, e);
      end
    for (int v = 0; v < 2; v++)
      for (int hh = 0; hh < 2; hh++) begin
        int e = rsad(t, 8*v, 8, 8*hh, 8);
        int a = int'(sad8x8[(2*v+hh)*14 +: 14]);
        chk(a == e, {tg, "/R3 8x8"}, a, e);
      end
    for (int i = 0; i < 2; i++) begin
      int e1 = rsad(t, 8*i, 8, 0, 16);
      int e2 = rsad(t, 0, 16, 8*i, 8);
      chk(int'(sad16x8[i*15 +: 15]) == e1, {tg, "/R4 16x8"}, int'(sad16x8[i*15 +: 15]), e1);
      chk(int'(sad8x16[i*15 +: 15]) == e2, {tg, "/R4 8x16"}, int'(sad8x16[i*15 +: 15]), e2);
    end
    begin
      int e = rsad(t, 0, 16, 0, 16);
      chk(int'(sad16x16) == e, {tg, "/R5 16x16"}, int'(sad16x16), e);
    end
  endtask

  task automatic step(input bit v, input bit sw, input bit le, input int lrow,
                      input logic [127:0] lpix, input logic [127:0] rpix);
    logic [15:0]  p16 = sad16x16;
    logic [103:0] p84 = sad8x4;
    ref_valid = v; mb_switch = sw; ld_en = le; ld_row = 4'(lrow); ld_pix = lpix; ref_pix = rpix;
    if (v) begin
      if (sw) begin
        for (int r = 0; r < 16; r++)
          for (int c = 0; c < 16; c++) snaps[nsnap][r][c] = shm[r][c];
        cur_id = nsnap;
        nsnap++;
      end
      for (int c = 0; c < 16; c++) hist[h][c] = rpix[c*8 +: 8];
      selhist[h] = cur_id;
    end
    if (le) for (int c = 0; c < 16; c++) shm[lrow][c] = lpix[c*8 +: 8];
    @(posedge clk);
    @(negedge clk);
    if (v) begin
      h++;
      if (h >= 16) begin
        chk(sad_valid == 1'b1, "R6 valid", int'(sad_valid), 1);
        check_cand(h - 16);
      end else
        chk(sad_valid == 1'b0, "R1 warmup", int'(sad_valid), 0);
    end else begin
      chk(sad_valid == 1'b0, "R7 idle valid", int'(sad_valid), 0);
      chk(sad16x16 == p16 && sad8x4 == p84, "R7 idle hold", int'(sad16x16), int'(p16));
    end
    ref_valid = 0; mb_switch = 0; ld_en = 0;
  endtask

  initial begin
    rst_n = 0; ld_en = 0; ld_row = 0; ld_pix = '0; ref_valid = 0; ref_pix = '0; mb_switch = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(sad_valid == 0 && sad16x16 == 0 && sad8x4 == 0 && sad8x8 == 0, "R1 reset", int'(sad16x16), 0);
    rst_n = 1;
    @(negedge clk);

    for (int e = 0; e < 5; e++) begin
      int cm = int'(VEC[e][7:4]);
      int rm = int'(VEC[e][3:0]);
      for (int r = 0; r < 16; r++) step(0, 0, 1, r, mkrow(cm, r), '0);
      for (int i = 0; i < 24; i++) step(1, i == 0, 0, 0, '0, mkrow(rm, i));
    end

    for (int i = 0; i < 12; i++) step(i % 2 == 0, 0, 0, 0, '0, mkrow(2, i));

    r9_phase = 1;
    for (int i = 0; i < 20; i++) step(1, 0, 1, i % 16, mkrow(2, i), mkrow(2, i));
    r9_phase = 0;

    rst_n = 0;
    @(negedge clk);
    chk(sad_valid == 0 && sad16x16 == 0, "R1 mid reset", int'(sad16x16), 0);
    rst_n = 1; h = 0;
    @(negedge clk);
    for (int i = 0; i < 18; i++) step(1, 0, 0, 0, '0, mkrow(2, i));

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL R6 watchdog expired got 0 exp 1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule